// File: doc/BRIEF.md
# Channel Fault Guard

This block guards one low-side power channel. It sits between the channel's active-low command input, four analog comparator flags (overcurrent, overtemperature, drain-below-threshold, load-current-below-threshold) and the gate-enable of the output stage. All filtering runs on a slow oscillator tick (`osc_tick`, a one-cycle enable at roughly 325 kHz) inside a faster system clock.

A short deglitch counter qualifies overcurrent. A confirmed overcurrent, or any overtemperature seen while the stage conducts, turns the gate off. The gate stays off until the command is taken away and given again. A longer counter qualifies the two slow checks. It is shared: while the gate is off it watches the drain comparator (short to ground), and while the gate is on it watches the load-current comparator (open load). Any change of channel state restarts it. Qualified faults leave the block as one-cycle event pulses, which feed a failure register.

The channel controller has three states. `ST_OFF` is gate off and idle. `ST_ON` is gate on. `ST_TRIP` is gate off after a short or overtemperature. The named transitions are:
- power-up: `ST_OFF` to `ST_ON` when the command is on.
- release: `ST_ON` to `ST_OFF` when the command is off.
- trip: `ST_ON` to `ST_TRIP` on a fault.
- rearm: `ST_TRIP` to `ST_OFF` when the command is off.
- force-off: any state to `ST_OFF` on undervoltage.

The asynchronous reset `rst_n` and the synchronous `undervolt` input both put the controller in `ST_OFF` and clear every counter.

Top module: `chan_fault_guard`

## Requirements
- R1: While `rst_n` is low or `undervolt` is high, `gate_en` is 0 and no event is emitted. Both counters restart from zero.
- R2: `ctl_n` = 0 commands the channel on and `ctl_n` = 1 commands it off. `gate_en` follows the command at the first clock edge that samples it.
- R3: Overcurrent while `gate_en` = 1 for `SC_TICKS` consecutive ticks (default 5) clears `gate_en` and pulses `ev_scb` for one cycle. Both happen at the edge that takes the last tick.
- R4: If overcurrent drops before `SC_TICKS` ticks, the short counter restarts and the gate stays on.
- R5: Overtemperature while `gate_en` = 1 clears `gate_en` and pulses `ev_scb` at the next edge. Overtemperature while the gate is off has no effect.
- R6: After a trip, `gate_en` stays 0 while `ctl_n` stays 0. It returns only after `ctl_n` goes to 1 and then back to 0.
- R7: `drain_low` while the gate is off for `FLT_TICKS` consecutive ticks (default 80) pulses `ev_scg` once. Further ticks in the same episode give no further pulse.
- R8: `cur_low` while the gate is on for `FLT_TICKS` consecutive ticks pulses `ev_ol` once.
- R9: The shared counter restarts when the watched flag drops and when the channel changes state.
- R10: If a trip and an open-load qualification fall on the same edge, only `ev_scb` pulses. At most one event pulses in any cycle.
- R11: `cur_low` has no effect while the gate is off, and `drain_low` has no effect while the gate is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| undervolt | input | 1 | Supply undervoltage, forces off and clears |
| osc_tick | input | 1 | One-cycle filter time base enable |
| ctl_n | input | 1 | Channel command, 0 = on |
| oc_flag | input | 1 | Overcurrent comparator |
| ot_flag | input | 1 | Overtemperature comparator |
| drain_low | input | 1 | Drain below short-to-ground threshold |
| cur_low | input | 1 | Load current below open-load threshold |
| gate_en | output | 1 | Output stage gate enable |
| ev_scb | output | 1 | Short-to-battery / overtemperature event pulse |
| ev_scg | output | 1 | Short-to-ground event pulse |
| ev_ol | output | 1 | Open-load event pulse |

## Verification
A confirmed short and an expiring open-load count can land on the same tick. Both need the gate on, and each would emit its own event. The bench provokes this case by first holding `cur_low` for `FLT_TICKS - SC_TICKS` ticks and then raising `oc_flag` as well. The two counters then expire on the same tick. At the negative edge after that tick, the bench requires `ev_scb` high, `ev_ol` low and the gate off, and later confirms that the open-load event count did not move.

// File: rtl/chan_guard_pkg.sv
package chan_guard_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON   = 2'd1,
        ST_TRIP = 2'd2
    } chan_state_t;
endpackage

// File: rtl/guard_tick_filter.sv
// Counts oscillator ticks while a flag is held; fires once at LIMIT.
module guard_tick_filter #(
    parameter int LIMIT = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic mon,
    input  logic tick,
    output logic fire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] FULL = CW'(LIMIT);

    logic [CW-1:0] cnt;

    assign fire = mon && tick && !clr && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !mon) begin
            cnt <= '0;
        end else if (tick && cnt != FULL) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
    import chan_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        uv,
    input  logic        cmd_on,
    input  logic        ot_flag,
    input  logic        sc_fire,
    output chan_state_t state,
    output logic        state_chg,
    output logic        trip
);
    chan_state_t state_nx;

    assign trip = (state == ST_ON) && !uv && (ot_flag || sc_fire);

    always_comb begin
        state_nx = state;
        if (uv) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  if (cmd_on) state_nx = ST_ON;
                ST_ON: begin
                    if (trip)         state_nx = ST_TRIP;
                    else if (!cmd_on) state_nx = ST_OFF;
                end
                ST_TRIP: if (!cmd_on) state_nx = ST_OFF;
                default: state_nx = ST_OFF;
            endcase
        end
    end

    assign state_chg = (state_nx != state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end
endmodule

// File: rtl/chan_fault_guard.sv
module chan_fault_guard
    import chan_guard_pkg::*;
#(
    parameter int SC_TICKS  = 5,
    parameter int FLT_TICKS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic undervolt,
    input  logic osc_tick,
    input  logic ctl_n,
    input  logic oc_flag,
    input  logic ot_flag,
    input  logic drain_low,
    input  logic cur_low,
    output logic gate_en,
    output logic ev_scb,
    output logic ev_scg,
    output logic ev_ol
);
    chan_state_t state;
    logic state_chg, trip, sc_fire, flt_fire, gate_on, flt_mon;

    assign gate_on = (state == ST_ON);
    assign flt_mon = gate_on ? cur_low : drain_low;

    guard_tick_filter #(.LIMIT(SC_TICKS)) u_sc_filt (
        .clk(clk), .rst_n(rst_n), .clr(undervolt),
        .mon(oc_flag && gate_on), .tick(osc_tick), .fire(sc_fire)
    );

    guard_tick_filter #(.LIMIT(FLT_TICKS)) u_slow_filt (
        .clk(clk), .rst_n(rst_n), .clr(undervolt || state_chg),
        .mon(flt_mon), .tick(osc_tick), .fire(flt_fire)
    );

    guard_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .uv(undervolt), .cmd_on(!ctl_n),
        .ot_flag(ot_flag), .sc_fire(sc_fire),
        .state(state), .state_chg(state_chg), .trip(trip)
    );

    assign gate_en = gate_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_scb <= 1'b0;
            ev_scg <= 1'b0;
            ev_ol  <= 1'b0;
        end else begin
            ev_scb <= trip;
            ev_scg <= flt_fire && !gate_on;
            ev_ol  <= flt_fire && gate_on && !trip;
        end
    end
endmodule

// File: rtl/chan_fault_guard_chk.sv
module chan_fault_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic undervolt,
    input logic osc_tick,
    input logic ctl_n,
    input logic oc_flag,
    input logic ot_flag,
    input logic drain_low,
    input logic cur_low,
    input logic gate_en,
    input logic ev_scb,
    input logic ev_scg,
    input logic ev_ol
);
    // R1
    uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undervolt |=> (!gate_en && !ev_scb && !ev_scg && !ev_ol));
    // R2
    on_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past(!ctl_n));
    // R3
    trip_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_scb |-> !gate_en);
    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_scb, ev_scg, ev_ol}));
    // R7
    scg_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_scg |-> ($past(!gate_en) && $past(drain_low)));
    // R8
    ol_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ol |-> ($past(gate_en) && $past(cur_low)));
endmodule

bind chan_fault_guard chan_fault_guard_chk chk_i (.*);

// File: tb/chan_fault_guard_test.sv
module chan_fault_guard_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic undervolt = 1'b0, osc_tick = 1'b0, ctl_n = 1'b1;
    logic oc_flag = 1'b0, ot_flag = 1'b0, drain_low = 1'b0, cur_low = 1'b0;
    logic gate_en, ev_scb, ev_scg, ev_ol;
    int tests = 0, fails = 0;
    int n_scb = 0, n_scg = 0, n_ol = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chan_fault_guard uut (.*);

    always @(negedge clk) begin
        if (ev_scb) n_scb++;
        if (ev_scg) n_scg++;
        if (ev_ol)  n_ol++;
    end

    // row: ctl_n oc ot drain cur ticks exp_gate d_scb d_scg d_ol
    typedef struct packed {
        logic       c_n, oc, ot, dl, cl;
        logic [7:0] ticks;
        logic       g, scb, scg, ol;
    } vec_t;
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'd0,  1'b0,1'b0,1'b0,1'b0}, // R2 off
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  1'b1,1'b0,1'b0,1'b0}, // R2 on
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'd100,1'b1,1'b0,1'b0,1'b0}, // R11 drain ignored on
        '{1'b1,1'b0,1'b0,1'b0,1'b1,8'd100,1'b0,1'b0,1'b0,1'b0}, // R11 cur ignored off
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'd80, 1'b0,1'b0,1'b1,1'b0}, // R7 scg
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'd50, 1'b0,1'b0,1'b0,1'b0}, // R7 once
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'd79, 1'b1,1'b0,1'b0,1'b0}, // R8 not yet
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'd1,  1'b1,1'b0,1'b0,1'b1}, // R8 ol
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'd5,  1'b0,1'b1,1'b0,1'b0}, // R3 trip
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  1'b0,1'b0,1'b0,1'b0}, // R6 stays off
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'd0,  1'b0,1'b0,1'b0,1'b0}, // R6 release
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  1'b1,1'b0,1'b0,1'b0}, // R6 rearmed
        '{1'b0,1'b0,1'b1,1'b0,1'b0,8'd0,  1'b0,1'b1,1'b0,1'b0}  // R5 overtemp
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // each tick: enable high for one cycle, low for one cycle
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            osc_tick = 1'b1; step(1);
            osc_tick = 1'b0; step(1);
        end
    endtask

    task automatic one_tick_then_look;
        osc_tick = 1'b1; step(1);
        osc_tick = 1'b0;
    endtask

    task automatic rearm;
        ctl_n = 1'b1; step(2);
        ctl_n = 1'b0; step(2);
    endtask

    initial begin
        int b_scb, b_scg, b_ol;
        step(3);
        check(gate_en == 1'b0 && !ev_scb && !ev_scg && !ev_ol, "R1 reset", gate_en, 0);
        rst_n = 1'b1;
        step(2);

        for (int v = 0; v < NV; v++) begin
            b_scb = n_scb; b_scg = n_scg; b_ol = n_ol;
            ctl_n = VECS[v].c_n; oc_flag = VECS[v].oc; ot_flag = VECS[v].ot;
            drain_low = VECS[v].dl; cur_low = VECS[v].cl;
            step(1);
            ticks(int'(VECS[v].ticks));
            step(2);
            check(gate_en == VECS[v].g, $sformatf("vec %0d gate (R2/R3/R5/R6)", v),
                  gate_en, VECS[v].g);
            check(n_scb - b_scb == int'(VECS[v].scb) && n_scg - b_scg == int'(VECS[v].scg)
                  && n_ol - b_ol == int'(VECS[v].ol),
                  $sformatf("vec %0d events (R3/R5/R7/R8/R11)", v),
                  (n_scb - b_scb) * 100 + (n_scg - b_scg) * 10 + (n_ol - b_ol),
                  int'(VECS[v].scb) * 100 + int'(VECS[v].scg) * 10 + int'(VECS[v].ol));
        end

        // R4 / R3: interrupted overcurrent restarts, then exact-tick trip
        ot_flag = 1'b0; oc_flag = 1'b0; cur_low = 1'b0; drain_low = 1'b0;
        rearm;
        b_scb = n_scb;
        oc_flag = 1'b1; ticks(4);
        oc_flag = 1'b0; step(1);
        oc_flag = 1'b1; ticks(4);
        check(gate_en == 1'b1 && n_scb == b_scb, "R4 restart", gate_en, 1);
        one_tick_then_look;
        check(gate_en == 1'b0 && ev_scb == 1'b1, "R3 same edge", {gate_en, ev_scb}, 1);
        oc_flag = 1'b0;

        // R5: overtemperature ignored while off
        ctl_n = 1'b1; step(2);
        b_scb = n_scb;
        ot_flag = 1'b1; step(5);
        ot_flag = 1'b0; step(2);
        check(n_scb == b_scb && gate_en == 1'b0, "R5 off ignored", n_scb - b_scb, 0);

        // R9: toggle restarts the shared counter
        b_scg = n_scg;
        drain_low = 1'b1; ticks(60);
        ctl_n = 1'b0; step(1);
        ctl_n = 1'b1; step(1);
        ticks(60);
        step(2);
        check(n_scg == b_scg, "R9 toggle restart", n_scg - b_scg, 0);
        ticks(20); step(2);
        check(n_scg == b_scg + 1, "R9 full count after toggle", n_scg - b_scg, 1);
        // R9: flag drop restarts
        drain_low = 1'b0; step(1);
        drain_low = 1'b1; ticks(79); step(2);
        check(n_scg == b_scg + 1, "R9 drop restart", n_scg - b_scg, 1);
        ticks(1); step(2);
        check(n_scg == b_scg + 2, "R9 drop then full", n_scg - b_scg, 2);
        drain_low = 1'b0;

        // R10: trip and open-load expiry on the same tick
        ctl_n = 1'b0; step(2);
        b_ol = n_ol;
        cur_low = 1'b1; ticks(75);
        oc_flag = 1'b1; ticks(4);
        one_tick_then_look;
        check(ev_scb == 1'b1 && ev_ol == 1'b0 && gate_en == 1'b0, "R10 priority",
              {ev_scb, ev_ol, gate_en}, 4);
        step(3);
        check(n_ol == b_ol, "R10 no open-load", n_ol - b_ol, 0);
        oc_flag = 1'b0; cur_low = 1'b0;

        // R1: undervoltage forces off and clears
        rearm;
        check(gate_en == 1'b1, "R6 rearm before R1", gate_en, 1);
        undervolt = 1'b1; step(2);
        check(gate_en == 1'b0, "R1 undervolt off", gate_en, 0);
        b_ol = n_ol;
        cur_low = 1'b1; ticks(90); step(1);
        check(n_ol == b_ol && gate_en == 1'b0, "R1 no events in undervolt", n_ol - b_ol, 0);
        undervolt = 1'b0; step(2);
        check(gate_en == 1'b1, "R1 recover on", gate_en, 1);
        ticks(79); step(2);
        check(n_ol == b_ol, "R1 counter cleared", n_ol - b_ol, 0);
        ticks(1); step(2);
        check(n_ol == b_ol + 1, "R8 after recovery", n_ol - b_ol, 1);
        cur_low = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule